// File: doc/BRIEF.md
# DMA Channel Address and Count Register File

This block holds the per-channel start address and block count of a four-channel DMA engine, together with each channel's running state: the current address origin and the number of units moved so far. Software reaches the two 16-bit registers of every channel through an 8-bit port. One byte-pointer flip-flop, shared by all channels, decides whether the low or the high byte moves on each access. Completing the high byte of a register restarts that channel's running state.

Read-back is computed rather than stored. The address register returns the origin moved forward or backward by the progress so far. The count register returns the scaled start count less the progress. A width input selects byte-wide or word-wide operation. In word-wide mode the port index is taken one bit higher, and values are held in units of two bytes. A progress port from the transfer engine updates a channel's transferred count. A query port gives the transfer engine a channel's live address, remaining count and block length. A clear input from the control-port decoder forces the byte pointer back to the low byte.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset every base register, origin, transferred count, the byte pointer and all outputs are 0.
- R2: The register index is `port[3:0]` when `wide`=0 and `port[4:1]` when `wide`=1. Index values 0 to 7 address channel `index[2:1]`, with `index[0]`=0 selecting the address register and 1 the count register. Index values 8 to 15 are ignored: no state changes, no toggle and no `rvalid`.
- R3: Every channel register access, read or write, flips the shared byte pointer. Pointer 0 selects the low byte.
- R4: A write with pointer 0 replaces bits 7:0 of the register and nothing else. A write with pointer 1 replaces bits 15:8, then sets that channel's origin to the base address shifted left by `wide` and its transferred count to 0.
- R5: The address read value is origin plus transferred when the channel's `dir_down` bit is 0, and origin minus transferred when it is 1, modulo 2^17.
- R6: The count read value is (base count << `wide`) minus transferred, modulo 2^17.
- R7: A read returns bits [`wide`+8*p +: 8] of the read value, where p is the pointer before the access. `rdata` is updated with `rvalid`=1 on the edge that takes the read.
- R8: `clear_ff` sets the pointer to 0 and wins over a toggle in the same cycle. An access in that cycle still uses the old pointer.
- R9: `prog_valid` loads `prog_count` into the transferred count of channel `prog_ch`. A high-byte write to the same channel in the same cycle wins and clears the count.
- R10: One edge after `q_ch` is presented, `q_addr` and `q_remain` carry that channel's R5 and R6 values, and `q_len` carries (base count + 1) << `wide`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide | input | 1 | 0 byte-wide, 1 word-wide operation |
| bus_en | input | 1 | Port access strobe, one cycle per access |
| bus_wr | input | 1 | 1 write, 0 read |
| port | input | 5 | Port offset of the access |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte, registered |
| rvalid | output | 1 | rdata updated by a read on the last edge |
| clear_ff | input | 1 | Force the byte pointer to the low byte |
| dir_down | input | 4 | Per-channel address direction, 1 counts down |
| prog_valid | input | 1 | Progress update strobe |
| prog_ch | input | 2 | Channel of the progress update |
| prog_count | input | 17 | New transferred count |
| q_ch | input | 2 | Channel queried by the transfer engine |
| q_addr | output | 17 | Live address of the queried channel |
| q_remain | output | 17 | Remaining count of the queried channel |
| q_len | output | 18 | Block length of the queried channel |

## Verification
A byte pointer that is out of step shows on the very next read as the wrong half of a value. It then stays wrong for every later read until a clear, so the bench re-reads after ignored control-range accesses and after a clear that coincides with an access. A missed or misdirected re-initialisation shows on the query port one edge later as a stale address or a non-zero progress. A wrong sign or scaling in the read arithmetic shows on the first read after a progress update, in down mode and in word-wide mode.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

  typedef enum logic {
    SEL_ADDR = 1'b0,
    SEL_CNT  = 1'b1
  } reg_sel_e;

  // byte lane extraction: shift by the width setting plus 8 for the high byte
  function automatic logic [7:0] pick_byte(input logic [31:0] v,
                                           input logic wide_i,
                                           input logic hi);
    logic [31:0] t;
    t = v >> (5'({hi, 3'b000}) + 5'(wide_i));
    return t[7:0];
  endfunction

endpackage

// File: rtl/dma_port_decode.sv
module dma_port_decode #(
  parameter int PORT_W = 5,
  parameter int CH_W   = 2
) (
  input  logic                  en,
  input  logic                  wr,
  input  logic                  wide,
  input  logic [PORT_W-1:0]     port,
  output logic                  rd_hit,
  output logic                  wr_hit,
  output logic [CH_W-1:0]       ch,
  output dma_regs_pkg::reg_sel_e sel
);
  localparam int IDX_W = CH_W + 2;

  logic [IDX_W-1:0] idx;
  logic             chan_range;

  assign idx        = wide ? port[IDX_W:1] : port[IDX_W-1:0];
  assign chan_range = ~idx[IDX_W-1];
  assign ch         = idx[CH_W:1];
  assign sel        = dma_regs_pkg::reg_sel_e'(idx[0]);
  assign rd_hit     = en & ~wr & chan_range;
  assign wr_hit     = en &  wr & chan_range;
endmodule

// File: rtl/dma_byte_ptr.sv
module dma_byte_ptr (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic toggle,
  output logic ptr
);
  always_ff @(posedge clk) begin
    if (rst)        ptr <= 1'b0;
    else if (clear) ptr <= 1'b0;
    else if (toggle) ptr <= ~ptr;
  end
endmodule

// File: rtl/dma_chan_slot.sv
module dma_chan_slot #(
  parameter int BASE_W = 16,
  localparam int VAL_W = BASE_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  dma_regs_pkg::reg_sel_e sel,
  input  logic [7:0]        wdata,
  input  logic              prog_we,
  input  logic [VAL_W-1:0]  prog_val,
  output logic [BASE_W-1:0] base_addr,
  output logic [BASE_W-1:0] base_cnt,
  output logic [VAL_W-1:0]  origin,
  output logic [VAL_W-1:0]  moved
);
  import dma_regs_pkg::*;

  logic [BASE_W-1:0] addr_after;

  // base address as it stands once this cycle's high-byte write lands
  always_comb begin
    addr_after = base_addr;
    if (wr_hi && sel == SEL_ADDR) addr_after[BASE_W-1:8] = wdata[BASE_W-9:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_addr <= '0;
      base_cnt  <= '0;
      origin    <= '0;
      moved     <= '0;
    end else begin
      if (wr_lo) begin
        if (sel == SEL_ADDR) base_addr[7:0] <= wdata;
        else                 base_cnt[7:0]  <= wdata;
      end
      if (wr_hi) begin
        if (sel == SEL_CNT) base_cnt[BASE_W-1:8] <= wdata[BASE_W-9:0];
        base_addr <= addr_after;
        origin    <= VAL_W'(addr_after) << wide;
        moved     <= '0;
      end else if (prog_we) begin
        moved <= prog_val;
      end
    end
  end
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs #(
  parameter int NUM_CH = 4,
  parameter int BASE_W = 16,
  parameter int PORT_W = 5,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int VAL_W = BASE_W + 1,
  localparam int LEN_W = BASE_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [PORT_W-1:0] port,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              rvalid,
  input  logic              clear_ff,
  input  logic [NUM_CH-1:0] dir_down,
  input  logic              prog_valid,
  input  logic [CH_W-1:0]   prog_ch,
  input  logic [VAL_W-1:0]  prog_count,
  input  logic [CH_W-1:0]   q_ch,
  output logic [VAL_W-1:0]  q_addr,
  output logic [VAL_W-1:0]  q_remain,
  output logic [LEN_W-1:0]  q_len
);
  import dma_regs_pkg::*;

  logic            rd_hit, wr_hit;
  logic [CH_W-1:0] acc_ch;
  reg_sel_e        acc_sel;
  logic            ff;

  dma_port_decode #(.PORT_W(PORT_W), .CH_W(CH_W)) u_dec (
    .en(bus_en), .wr(bus_wr), .wide(wide), .port(port),
    .rd_hit(rd_hit), .wr_hit(wr_hit), .ch(acc_ch), .sel(acc_sel)
  );

  dma_byte_ptr u_ptr (
    .clk(clk), .rst(rst), .clear(clear_ff),
    .toggle(rd_hit | wr_hit), .ptr(ff)
  );

  logic [BASE_W-1:0] base_addr [NUM_CH];
  logic [BASE_W-1:0] base_cnt  [NUM_CH];
  logic [VAL_W-1:0]  origin    [NUM_CH];
  logic [VAL_W-1:0]  moved     [NUM_CH];
  logic [VAL_W-1:0]  addr_val  [NUM_CH];
  logic [VAL_W-1:0]  cnt_val   [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic hit;
    assign hit = wr_hit && (acc_ch == CH_W'(i));

    dma_chan_slot #(.BASE_W(BASE_W)) u_slot (
      .clk(clk), .rst(rst), .wide(wide),
      .wr_lo(hit & ~ff), .wr_hi(hit & ff), .sel(acc_sel), .wdata(wdata),
      .prog_we(prog_valid && (prog_ch == CH_W'(i))), .prog_val(prog_count),
      .base_addr(base_addr[i]), .base_cnt(base_cnt[i]),
      .origin(origin[i]), .moved(moved[i])
    );

    assign addr_val[i] = dir_down[i] ? (origin[i] - moved[i])
                                     : (origin[i] + moved[i]);
    assign cnt_val[i]  = (VAL_W'(base_cnt[i]) << wide) - moved[i];
  end

  logic [VAL_W-1:0] rd_val;
  assign rd_val = (acc_sel == SEL_CNT) ? cnt_val[acc_ch] : addr_val[acc_ch];

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= rd_hit;
      if (rd_hit) rdata <= pick_byte(32'(rd_val), wide, ff);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      q_addr   <= '0;
      q_remain <= '0;
      q_len    <= '0;
    end else begin
      q_addr   <= addr_val[q_ch];
      q_remain <= cnt_val[q_ch];
      q_len    <= (LEN_W'(base_cnt[q_ch]) + LEN_W'(1)) << wide;
    end
  end
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter int PORT_W = 5,
  parameter int LEN_W  = 18
) (
  input logic              clk,
  input logic              rst,
  input logic              wide,
  input logic              bus_en,
  input logic              bus_wr,
  input logic [PORT_W-1:0] port,
  input logic              clear_ff,
  input logic              ff,
  input logic              rvalid,
  input logic [LEN_W-1:0]  q_len
);
  localparam int IDX_W = 4;
  logic [IDX_W-1:0] idx;
  logic             chan_acc;
  assign idx      = wide ? port[IDX_W:1] : port[IDX_W-1:0];
  assign chan_acc = bus_en && (idx < 4'd8);

  // R3
  ff_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (chan_acc && !clear_ff) |=> (ff != $past(ff)));

  // R2
  ff_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!chan_acc && !clear_ff) |=> $stable(ff));

  // R8
  ff_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clear_ff |=> (ff == 1'b0));

  // R7
  rvalid_chk: assert property (@(posedge clk) disable iff (rst)
    (chan_acc && !bus_wr) |=> rvalid);

  // R2
  no_rvalid_chk: assert property (@(posedge clk) disable iff (rst)
    !(chan_acc && !bus_wr) |=> !rvalid);

  // R10
  len_even_chk: assert property (@(posedge clk) disable iff (rst)
    wide |=> (q_len[0] == 1'b0));
endmodule

bind dma_chan_regs dma_chan_regs_chk #(.PORT_W(PORT_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .wide(wide), .bus_en(bus_en), .bus_wr(bus_wr),
  .port(port), .clear_ff(clear_ff), .ff(ff), .rvalid(rvalid), .q_len(q_len)
);

// File: tb/tb_dma_chan_regs.sv
module tb_dma_chan_regs;
  logic clk = 1'b0, rst = 1'b1;
  always #4 clk = ~clk;

  logic        wide = 0, bus_en = 0, bus_wr = 0, clear_ff = 0, prog_valid = 0;
  logic [4:0]  port = 0;
  logic [7:0]  wdata = 0, rdata;
  logic        rvalid;
  logic [3:0]  dir_down = 0;
  logic [1:0]  prog_ch = 0, q_ch = 0;
  logic [16:0] prog_count = 0, q_addr, q_remain;
  logic [17:0] q_len;

  dma_chan_regs dut (.*);

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model
  logic [15:0] m_ba [4], m_bc [4];
  logic [16:0] m_or [4], m_mv [4];
  logic        m_ff;

  int exp_q[$], req_q[$];

  function automatic logic [16:0] m_addr(int c);
    return dir_down[c] ? m_or[c] - m_mv[c] : m_or[c] + m_mv[c];
  endfunction
  function automatic logic [16:0] m_cnt(int c);
    logic [16:0] b;
    b = {1'b0, m_bc[c]} << wide;
    return b - m_mv[c];
  endfunction

  task automatic check(int req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops one expected byte per rvalid
  always @(negedge clk) begin
    if (!rst && rvalid) begin
      if (exp_q.size() == 0) check(2, 32'(rdata), 32'hDEAD);
      else begin
        int e, r;
        e = exp_q.pop_front(); r = req_q.pop_front();
        check(r, 32'(rdata), 32'(e));
      end
    end
  end

  // one access; clr also pulses clear_ff; pg/pc/pv add a progress update
  task automatic acc(bit wr, logic [4:0] p, logic [7:0] d, int req,
                     bit clr = 0, bit pg = 0, int pc = 0, logic [16:0] pv = 0);
    logic [3:0] idx;
    int c;
    @(negedge clk);
    bus_en = 1; bus_wr = wr; port = p; wdata = d; clear_ff = clr;
    prog_valid = pg; prog_ch = 2'(pc); prog_count = pv;
    idx = wide ? p[4:1] : p[3:0];
    c = int'(idx[2:1]);
    if (pg) m_mv[pc] = pv;
    if (!idx[3]) begin
      if (!wr) begin
        logic [16:0] v;
        logic [16:0] t;
        v = idx[0] ? m_cnt(c) : m_addr(c);
        t = v >> (int'(wide) + 8 * int'(m_ff));
        exp_q.push_back(int'(t[7:0])); req_q.push_back(req);
      end else if (!m_ff) begin
        if (idx[0]) m_bc[c][7:0] = d; else m_ba[c][7:0] = d;
      end else begin
        if (idx[0]) m_bc[c][15:8] = d; else m_ba[c][15:8] = d;
        m_or[c] = {1'b0, m_ba[c]} << wide;
        m_mv[c] = 0;
      end
      m_ff = ~m_ff;
    end
    if (clr) m_ff = 0;
    @(negedge clk);
    bus_en = 0; clear_ff = 0; prog_valid = 0;
  endtask

  task automatic prog(int c, logic [16:0] v);
    @(negedge clk);
    prog_valid = 1; prog_ch = 2'(c); prog_count = v; m_mv[c] = v;
    @(negedge clk);
    prog_valid = 0;
  endtask

  task automatic clr();
    @(negedge clk); clear_ff = 1; m_ff = 0;
    @(negedge clk); clear_ff = 0;
  endtask

  task automatic query(int c, int req);
    logic [17:0] l;
    @(negedge clk); q_ch = 2'(c);
    @(negedge clk);
    l = ({2'b0, m_bc[c]} + 18'd1) << wide;
    check(req, 32'(q_addr), 32'(m_addr(c)));
    check(req, 32'(q_remain), 32'(m_cnt(c)));
    check(req, 32'(q_len), 32'(l));
  endtask

  // p = register index; word mode places it one bit higher
  function automatic logic [4:0] pt(int idx);
    return wide ? 5'(idx << 1) : 5'(idx);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual hung expected done");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 4; i++) begin m_ba[i] = 0; m_bc[i] = 0; m_or[i] = 0; m_mv[i] = 0; end
    m_ff = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    check(1, 32'(rvalid), 0);
    query(0, 1);
    acc(0, pt(0), 0, 1); acc(0, pt(0), 0, 1);
    // R4 full write then R3/R7 read back both bytes
    acc(1, pt(2), 8'h34, 4); acc(1, pt(2), 8'h12, 4);
    acc(0, pt(2), 0, 7); acc(0, pt(2), 0, 3);
    acc(1, pt(3), 8'hFF, 4); acc(1, pt(3), 8'h00, 4);
    query(1, 10);
    // R9 progress, R5 up and down, R6 remaining
    prog(1, 17'h10);
    acc(0, pt(2), 0, 5); acc(0, pt(2), 0, 5);
    acc(0, pt(3), 0, 6); acc(0, pt(3), 0, 6);
    dir_down[1] = 1;
    acc(0, pt(2), 0, 5); acc(0, pt(2), 0, 5);
    query(1, 5);
    // R4 low byte alone does not reinitialise
    acc(1, pt(2), 8'h00, 4);
    clr();
    acc(0, pt(2), 0, 4); acc(0, pt(2), 0, 4);
    // R2 control-range indices ignored: pointer and state untouched
    acc(0, 5'h08, 0, 2); acc(1, 5'h0C, 8'h55, 2);
    acc(0, pt(3), 0, 2); acc(0, 5'h0F, 0, 2); acc(0, pt(3), 0, 2);
    // R8 clear with an access in the same cycle
    acc(0, pt(2), 0, 8);
    acc(0, pt(2), 0, 8, 1);
    acc(0, pt(2), 0, 8);
    clr();
    // R9 high write wins over progress on the same channel
    acc(1, pt(4), 8'h22, 9); acc(1, pt(4), 8'h11, 9, 0, 1, 2, 17'h77);
    query(2, 9);
    // wrap in down mode, R5
    dir_down[0] = 1; prog(0, 17'h1);
    acc(0, pt(0), 0, 5); acc(0, pt(0), 0, 5);
    // word-wide operation: R2 index, R7 scaling, R10 length
    clr(); wide = 1;
    acc(1, pt(6), 8'h01, 2); acc(1, pt(6), 8'h80, 4);
    acc(1, pt(7), 8'h03, 2); acc(1, pt(7), 8'h00, 4);
    prog(3, 17'h2);
    acc(0, pt(6), 0, 7); acc(0, pt(6), 0, 7);
    acc(0, pt(7), 0, 6); acc(0, pt(7), 0, 6);
    query(3, 10);
    repeat (4) @(negedge clk);
    check(7, exp_q.size(), 0);
    finish_run();
  end
endmodule